// File: doc/BRIEF.md
# Bridge Error Message Reporting Logic

This block sits on the upstream-facing side of a virtual PCI-to-PCI bridge port. Each cycle it looks at the error events raised in the port. Every event carries a severity (fatal or non-fatal) and the side of the bridge where it arose. From these it decides whether a system-error message must go upstream. It also keeps the two error status flags that record what happened.

A message can be allowed by either of two enable paths. The first is the command-register system-error enable. It admits any event detected on the primary side, whatever its severity, but never an event received from the secondary side. The second is the pair of device-control enables, one for fatal and one for non-fatal errors. These admit events of the matching severity from either side.

Whenever a message goes out, the signaled-system-error flag is set. A master data parity error sets its own flag, but only while parity-error response is enabled. Both flags hold until software writes a 1 to their bit position.

Top module: `brg_err_report`

## Requirements
- R1: A valid event with `evt_secondary`=0 while `cmd_serr_en`=1 raises `msg_req` in the next cycle, whatever its severity and whatever the device-control enables are.
- R2: An event with `evt_secondary`=1 never produces a message through `cmd_serr_en`. With both device-control enables at 0, such events leave `msg_req` and `sts_serr` at 0.
- R3: With `cmd_serr_en`=0, a valid event raises `msg_req` in the next cycle only if its severity's enable is 1. A fatal event (`evt_fatal`=1) needs `dc_fatal_en`. A non-fatal event (`evt_fatal`=0) needs `dc_nonfatal_en`. The side of the event does not matter on this path.
- R4: In the same cycle that `msg_req` is 1, `sts_serr` is 1.
- R5: `sts_mdpe` becomes 1 in the cycle after `mdpe_pulse`=1 while `cmd_perr_resp_en`=1. While `cmd_perr_resp_en`=0, `sts_mdpe` never becomes set.
- R6: In the cycle after `rst`=1, `msg_req`, `sts_serr` and `sts_mdpe` are all 0.
- R7: The status flags are sticky. A cycle with `sts_wr`=1 clears a flag in the next cycle only if its bit of `sts_wdata` is 1: bit 0 clears `sts_serr` and bit 1 clears `sts_mdpe`. A 0 in a bit leaves that flag unchanged.
- R8: Any number of qualifying events in one cycle yields a single one-cycle `msg_req` pulse. If no event follows, `msg_req` returns to 0 in the next cycle.
- R9: When a flag's set condition and its clear fall in the same cycle, the flag is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_serr_en | input | 1 | Command-register system-error enable (primary-side events only) |
| cmd_perr_resp_en | input | 1 | Command-register parity-error response enable |
| dc_fatal_en | input | 1 | Device-control fatal error reporting enable |
| dc_nonfatal_en | input | 1 | Device-control non-fatal error reporting enable |
| evt_valid | input | N_SRC | One pulse per error source |
| evt_fatal | input | N_SRC | Severity per source: 1 = fatal, 0 = non-fatal |
| evt_secondary | input | N_SRC | Side per source: 1 = received from secondary side, 0 = primary side |
| mdpe_pulse | input | 1 | Master data parity error seen this cycle |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 2 | Write-1-to-clear data: bit 0 = sts_serr, bit 1 = sts_mdpe |
| msg_req | output | 1 | One-cycle request to send a system-error message upstream |
| sts_serr | output | 1 | Sticky signaled-system-error flag |
| sts_mdpe | output | 1 | Sticky master data parity error flag |

## Verification
A wrong qualification term shows up one cycle after the offending event. Either `msg_req` and `sts_serr` rise when they should stay low, or they stay low when they should rise. Since both come from the same decision, the two ports must always agree in that cycle. A corrupted sticky flag shows up either as a flag that drops without a write of 1 or as a flag that survives a lone clear. Both are visible one cycle after the write. The bench arranges the writes so that each of these outcomes separates a correct flag from a broken one.

// File: rtl/brg_err_pkg.sv
package brg_err_pkg;

    typedef enum logic [0:0] {
        SEV_NONFATAL = 1'b0,
        SEV_FATAL    = 1'b1
    } err_sev_e;

    typedef enum logic [0:0] {
        SIDE_PRIMARY   = 1'b0,
        SIDE_SECONDARY = 1'b1
    } err_side_e;

    typedef struct packed {
        logic      valid;
        err_sev_e  sev;
        err_side_e side;
    } err_evt_t;

    typedef struct packed {
        logic cmd_serr_en;
        logic perr_resp_en;
        logic dc_fatal_en;
        logic dc_nonfatal_en;
    } err_ctl_t;

    localparam int STS_W        = 2;
    localparam int STS_SERR_BIT = 0;
    localparam int STS_MDPE_BIT = 1;

    // Either enable path may admit an event; the command path only sees
    // events that originate on the primary side.
    function automatic logic evt_admitted(err_evt_t e, err_ctl_t c);
        logic cmd_path;
        logic dc_path;
        cmd_path = c.cmd_serr_en && (e.side == SIDE_PRIMARY);
        dc_path  = (e.sev == SEV_FATAL) ? c.dc_fatal_en : c.dc_nonfatal_en;
        return e.valid && (cmd_path || dc_path);
    endfunction

endpackage

// File: rtl/brg_err_qualify.sv
module brg_err_qualify
    import brg_err_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  err_evt_t [N_SRC-1:0] evts,
    input  err_ctl_t             ctl,
    output logic                 any_hit
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_lane
        assign hit[i] = evt_admitted(evts[i], ctl);
    end

    assign any_hit = |hit;
endmodule

// File: rtl/brg_err_msg.sv
module brg_err_msg (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic req
);
    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= fire;
    end
endmodule

// File: rtl/brg_err_sticky.sv
module brg_err_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/brg_err_report.sv
module brg_err_report
    import brg_err_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_serr_en,
    input  logic             cmd_perr_resp_en,
    input  logic             dc_fatal_en,
    input  logic             dc_nonfatal_en,
    input  logic [N_SRC-1:0] evt_valid,
    input  logic [N_SRC-1:0] evt_fatal,
    input  logic [N_SRC-1:0] evt_secondary,
    input  logic             mdpe_pulse,
    input  logic             sts_wr,
    input  logic [1:0]       sts_wdata,
    output logic             msg_req,
    output logic             sts_serr,
    output logic             sts_mdpe
);
    err_ctl_t             ctl;
    err_evt_t [N_SRC-1:0] evts;
    logic                 fire;
    logic [STS_W-1:0]     sts_set;
    logic [STS_W-1:0]     sts_q;

    assign ctl = '{cmd_serr_en:    cmd_serr_en,
                   perr_resp_en:   cmd_perr_resp_en,
                   dc_fatal_en:    dc_fatal_en,
                   dc_nonfatal_en: dc_nonfatal_en};

    for (genvar i = 0; i < N_SRC; i++) begin : g_pack
        assign evts[i] = '{valid: evt_valid[i],
                           sev:   err_sev_e'(evt_fatal[i]),
                           side:  err_side_e'(evt_secondary[i])};
    end

    brg_err_qualify #(.N_SRC(N_SRC)) u_qual (
        .evts    (evts),
        .ctl     (ctl),
        .any_hit (fire)
    );

    brg_err_msg u_msg (
        .clk  (clk),
        .rst  (rst),
        .fire (fire),
        .req  (msg_req)
    );

    assign sts_set[STS_SERR_BIT] = fire;
    assign sts_set[STS_MDPE_BIT] = mdpe_pulse && ctl.perr_resp_en;

    for (genvar b = 0; b < STS_W; b++) begin : g_sts
        brg_err_sticky u_bit (
            .clk (clk),
            .rst (rst),
            .set (sts_set[b]),
            .clr (sts_wr && sts_wdata[b]),
            .q   (sts_q[b])
        );
    end

    assign sts_serr = sts_q[STS_SERR_BIT];
    assign sts_mdpe = sts_q[STS_MDPE_BIT];
endmodule

// File: rtl/brg_err_report_chk.sv
module brg_err_report_chk #(
    parameter int N_SRC = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_serr_en,
    input logic             cmd_perr_resp_en,
    input logic             dc_fatal_en,
    input logic             dc_nonfatal_en,
    input logic [N_SRC-1:0] evt_valid,
    input logic [N_SRC-1:0] evt_secondary,
    input logic             mdpe_pulse,
    input logic             sts_wr,
    input logic [1:0]       sts_wdata,
    input logic             msg_req,
    input logic             sts_serr,
    input logic             sts_mdpe
);
    AST_CMD_PRIMARY_FIRES: assert property (@(posedge clk) disable iff (rst)
        (cmd_serr_en && ((evt_valid & ~evt_secondary) != '0)) |=> msg_req); // R1

    AST_SECONDARY_NO_CMD: assert property (@(posedge clk) disable iff (rst)
        (!dc_fatal_en && !dc_nonfatal_en && ((evt_valid & ~evt_secondary) == '0)) |=> !msg_req); // R2

    AST_MSG_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        msg_req |-> sts_serr); // R4

    AST_MDPE_GATED: assert property (@(posedge clk) disable iff (rst)
        (!cmd_perr_resp_en && !sts_mdpe) |=> !sts_mdpe); // R5

    AST_MDPE_SETS: assert property (@(posedge clk) disable iff (rst)
        (cmd_perr_resp_en && mdpe_pulse) |=> sts_mdpe); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!msg_req && !sts_serr && !sts_mdpe)); // R6

    AST_SERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_serr && !(sts_wr && sts_wdata[0])) |=> sts_serr); // R7

    AST_MDPE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (sts_mdpe && !(sts_wr && sts_wdata[1])) |=> sts_mdpe); // R7

    AST_NO_IDLE_MSG: assert property (@(posedge clk) disable iff (rst)
        (evt_valid == '0) |=> !msg_req); // R8
endmodule

bind brg_err_report brg_err_report_chk #(.N_SRC(N_SRC)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .cmd_serr_en      (cmd_serr_en),
    .cmd_perr_resp_en (cmd_perr_resp_en),
    .dc_fatal_en      (dc_fatal_en),
    .dc_nonfatal_en   (dc_nonfatal_en),
    .evt_valid        (evt_valid),
    .evt_secondary    (evt_secondary),
    .mdpe_pulse       (mdpe_pulse),
    .sts_wr           (sts_wr),
    .sts_wdata        (sts_wdata),
    .msg_req          (msg_req),
    .sts_serr         (sts_serr),
    .sts_mdpe         (sts_mdpe)
);

// File: tb/brg_err_report_bench.sv
module brg_err_report_bench;
    localparam int N = 4;
    localparam int NV = 12;

    logic clk = 1'b0;
    logic rst;
    logic cmd_serr_en, cmd_perr_resp_en, dc_fatal_en, dc_nonfatal_en;
    logic [N-1:0] evt_valid, evt_fatal, evt_secondary;
    logic mdpe_pulse, sts_wr;
    logic [1:0] sts_wdata;
    logic msg_req, sts_serr, sts_mdpe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    brg_err_report #(.N_SRC(N)) u_brg_err_report (
        .clk(clk), .rst(rst),
        .cmd_serr_en(cmd_serr_en), .cmd_perr_resp_en(cmd_perr_resp_en),
        .dc_fatal_en(dc_fatal_en), .dc_nonfatal_en(dc_nonfatal_en),
        .evt_valid(evt_valid), .evt_fatal(evt_fatal), .evt_secondary(evt_secondary),
        .mdpe_pulse(mdpe_pulse), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .msg_req(msg_req), .sts_serr(sts_serr), .sts_mdpe(sts_mdpe)
    );

    // {cmd, perr, dcf, dcn} valid fatal secondary mdpe {exp_msg, exp_serr, exp_mdpe}
    localparam logic [19:0] VEC [NV] = '{
        20'b1000_0001_0000_0000_0_110,  // R1 primary non-fatal via command enable
        20'b1000_0010_0010_0000_0_110,  // R1 primary fatal via command enable
        20'b1000_0100_0000_0100_0_000,  // R2 secondary event, command enable only
        20'b0010_0001_0001_0001_0_110,  // R3 fatal enable, secondary fatal event
        20'b0010_0001_0000_0000_0_000,  // R3 fatal enable, non-fatal event
        20'b0001_1000_0000_1000_0_110,  // R3 non-fatal enable, secondary non-fatal
        20'b0001_0001_0001_0000_0_000,  // R3 non-fatal enable, fatal event
        20'b1011_1111_0101_0011_0_110,  // R8 several qualifying at once
        20'b0000_0000_0000_0000_1_000,  // R5 parity error with response off
        20'b0100_0000_0000_0000_1_001,  // R5 parity error with response on
        20'b1001_1111_1111_1111_0_000,  // R2 all secondary fatal, non-fatal enable only
        20'b0000_0000_0000_0000_0_000   // idle
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        {cmd_serr_en, cmd_perr_resp_en, dc_fatal_en, dc_nonfatal_en} = '0;
        evt_valid = '0; evt_fatal = '0; evt_secondary = '0;
        mdpe_pulse = 1'b0; sts_wr = 1'b0; sts_wdata = 2'b00;
    endtask

    task automatic clear_all();
        idle_inputs();
        sts_wr = 1'b1; sts_wdata = 2'b11;
        @(negedge clk);
        sts_wr = 1'b0; sts_wdata = 2'b00;
    endtask

    task automatic raise_serr();
        idle_inputs();
        cmd_serr_en = 1'b1; evt_valid = 4'b0001;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 reset msg_req", msg_req, 1'b0);
        chk("R6 reset sts_serr", sts_serr, 1'b0);
        chk("R6 reset sts_mdpe", sts_mdpe, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            clear_all();
            {cmd_serr_en, cmd_perr_resp_en, dc_fatal_en, dc_nonfatal_en} = VEC[v][19:16];
            evt_valid     = VEC[v][15:12];
            evt_fatal     = VEC[v][11:8];
            evt_secondary = VEC[v][7:4];
            mdpe_pulse    = VEC[v][3];
            @(negedge clk);
            chk($sformatf("R1/R3 table vec %0d msg_req", v), msg_req, VEC[v][2]);
            chk($sformatf("R4 table vec %0d sts_serr", v), sts_serr, VEC[v][1]);
            chk($sformatf("R5 table vec %0d sts_mdpe", v), sts_mdpe, VEC[v][0]);
            idle_inputs();
            @(negedge clk);
            chk($sformatf("R8 table vec %0d pulse ends", v), msg_req, 1'b0);
            chk($sformatf("R7 table vec %0d serr held", v), sts_serr, VEC[v][1]);
        end

        // R7: zero bits leave flags alone, one bits clear only their flag
        clear_all();
        raise_serr();
        cmd_perr_resp_en = 1'b1; mdpe_pulse = 1'b1;
        @(negedge clk);
        idle_inputs();
        sts_wr = 1'b1; sts_wdata = 2'b00;
        @(negedge clk);
        chk("R7 write zero keeps serr", sts_serr, 1'b1);
        chk("R7 write zero keeps mdpe", sts_mdpe, 1'b1);
        sts_wdata = 2'b10;
        @(negedge clk);
        chk("R7 bit1 clears mdpe", sts_mdpe, 1'b0);
        chk("R7 bit1 keeps serr", sts_serr, 1'b1);
        sts_wdata = 2'b01;
        @(negedge clk);
        chk("R7 bit0 clears serr", sts_serr, 1'b0);
        idle_inputs();

        // R9: set and clear collide
        clear_all();
        cmd_serr_en = 1'b1; evt_valid = 4'b0100;
        sts_wr = 1'b1; sts_wdata = 2'b01;
        @(negedge clk);
        chk("R9 serr set wins", sts_serr, 1'b1);
        idle_inputs();
        cmd_perr_resp_en = 1'b1; mdpe_pulse = 1'b1;
        sts_wr = 1'b1; sts_wdata = 2'b10;
        @(negedge clk);
        chk("R9 mdpe set wins", sts_mdpe, 1'b1);
        idle_inputs();

        // R8: back-to-back events give one pulse per event cycle
        clear_all();
        dc_fatal_en = 1'b1; evt_valid = 4'b0011; evt_fatal = 4'b0011;
        @(negedge clk);
        chk("R8 first cycle pulse", msg_req, 1'b1);
        @(negedge clk);
        chk("R8 second cycle pulse", msg_req, 1'b1);
        idle_inputs();
        @(negedge clk);
        chk("R8 stops after events", msg_req, 1'b0);

        // R6: reset in mid-run clears set flags
        raise_serr();
        cmd_perr_resp_en = 1'b1; mdpe_pulse = 1'b1;
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        chk("R6 mid reset serr", sts_serr, 1'b0);
        chk("R6 mid reset mdpe", sts_mdpe, 1'b0);
        rst = 1'b0;
        @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule